// File: doc/BRIEF.md
# Two-Level ALU Operation Select Decoder

This block turns a coarse operation class and an instruction's function field into the 3-bit operation select of a 32-bit ALU. The main controller decodes the opcode and reduces it to a 2-bit class. This block then produces the ALU select. Memory-reference and compare-for-branch classes map straight to a fixed operation. The register-arithmetic class hands the choice to the function field.

Control is split into two levels for a reason. The main controller never has to know the arithmetic function codes. This decoder never has to know the opcodes. The select uses a non-contiguous 3-bit encoding: bit 2 requests the inverted second operand with carry-in, and bits 1:0 pick the result path. That is why subtract is 110 rather than 011.

The block is purely combinational. It has no clock and no reset. A reserved class, or a function code outside the supported set, falls back to the add select and raises a flag that the controller can turn into an exception.

Top module: `alu_op_decoder`

## Requirements
- R1: With `op_class` = 00 (load/store), `alu_sel` is 010 (add) and `illegal_funct` is 0.
- R2: With `op_class` = 01 (branch-on-equal), `alu_sel` is 110 (subtract) and `illegal_funct` is 0.
- R3: With `op_class` = 10 (register arithmetic), the function codes map as follows, each with `illegal_funct` at 0: 0x20 gives 010 (add), 0x22 gives 110 (subtract), 0x24 gives 000 (AND), 0x25 gives 001 (OR), and 0x2A gives 111 (set-on-less-than).
- R4: With `op_class` = 10 and any other function code, `alu_sel` is 010 and `illegal_funct` is 1.
- R5: With `op_class` = 11 (reserved), `alu_sel` is 010 and `illegal_funct` is 1, whatever the function field holds.
- R6: Under classes 00 and 01, the function field has no effect on either output, for all 64 function values.
- R7: `alu_sel` only ever takes one of the values 000, 001, 010, 110 or 111.
- R8: When a 32-bit ALU is driven by `alu_sel`, each arithmetic function code produces its intended result. The result is a+b for add, a-b for subtract, a&b for AND and a|b for OR. For set-on-less-than it is 1 when a is less than b as signed numbers, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_class | input | 2 | Operation class from the main controller |
| funct | input | FUNCT_W (6) | Function field, the low bits of a register-format instruction word |
| alu_sel | output | SEL_W (3) | ALU operation select |
| illegal_funct | output | 1 | Reserved class or unsupported function code |

## Verification
A vector table first sets each class against function values that would mean something else under another class. An arithmetic code under the load/store class is one example. These vectors show whether the decoder looks at the function field only when it should. An exhaustive sweep of all 64 function values under all four classes then separates the five legal codes from their neighbours, such as unsigned compare and shift codes. It also shows that the function field is a don't-care elsewhere. Last, a reference ALU is driven by the decoded select with signed, carry-producing and equal operand pairs. This step catches a select that is legal but wrong, such as swapped subtract and compare encodings.

// File: rtl/alu_op_pkg.sv
package alu_op_pkg;

   localparam int OPSEL_BITS = 3;
   localparam int CLASS_BITS = 2;

   typedef logic [OPSEL_BITS-1:0] opsel_t;

   // operation class from the main controller
   typedef enum logic [CLASS_BITS-1:0] {
      CLS_MEM    = 2'b00,
      CLS_BRANCH = 2'b01,
      CLS_ARITH  = 2'b10,
      CLS_RSVD   = 2'b11
   } op_class_e;

   // ALU select encodings: bit 2 = invert operand b with carry-in,
   // bits 1:0 = result path (and / or / sum / less-than)
   localparam opsel_t SEL_AND = 3'b000;
   localparam opsel_t SEL_OR  = 3'b001;
   localparam opsel_t SEL_ADD = 3'b010;
   localparam opsel_t SEL_SUB = 3'b110;
   localparam opsel_t SEL_SLT = 3'b111;

   // supported function codes (register-format arithmetic)
   localparam logic [5:0] FN_ADD = 6'h20;
   localparam logic [5:0] FN_SUB = 6'h22;
   localparam logic [5:0] FN_AND = 6'h24;
   localparam logic [5:0] FN_OR  = 6'h25;
   localparam logic [5:0] FN_SLT = 6'h2A;

   function automatic logic sel_is_legal(opsel_t s);
      return (s == SEL_AND) || (s == SEL_OR) || (s == SEL_ADD) ||
             (s == SEL_SUB) || (s == SEL_SLT);
   endfunction

endpackage

// File: rtl/op_class_map.sv
// First control level: class code -> fixed select or hand-off to funct.
module op_class_map
   import alu_op_pkg::*;
#(
   parameter int SEL_W = 3
) (
   input  logic [CLASS_BITS-1:0] cls,
   output logic [SEL_W-1:0]      base_sel,
   output logic                  use_funct,
   output logic                  cls_bad
);

   always_comb begin
      base_sel  = SEL_ADD;
      use_funct = 1'b0;
      cls_bad   = 1'b0;
      unique case (op_class_e'(cls))
         CLS_MEM:    base_sel = SEL_ADD;
         CLS_BRANCH: base_sel = SEL_SUB;
         CLS_ARITH:  use_funct = 1'b1;
         CLS_RSVD:   cls_bad = 1'b1;
         default:    cls_bad = 1'b1;
      endcase
   end

   // class 11 never hands off to the function decoder
   always_comb begin
      assert_rsvd_no_handoff_R5: assert (!(cls_bad && use_funct))
         else $error("reserved class handed off to funct decode");
   end

endmodule

// File: rtl/funct_op_map.sv
// Second control level: function field -> ALU select.
module funct_op_map
   import alu_op_pkg::*;
#(
   parameter int FUNCT_W      = 6,
   parameter int SEL_W        = 3,
   parameter bit STRICT_FUNCT = 1'b1
) (
   input  logic [FUNCT_W-1:0] funct,
   output logic [SEL_W-1:0]   fn_sel,
   output logic               fn_bad
);

   localparam int FN_LO_W = 6;

   logic [FN_LO_W-1:0] fcode;
   assign fcode = funct[FN_LO_W-1:0];

   generate
      if (STRICT_FUNCT) begin : g_full
         // full compare of all six function bits
         always_comb begin
            fn_sel = SEL_ADD;
            fn_bad = 1'b0;
            unique case (fcode)
               FN_ADD:  fn_sel = SEL_ADD;
               FN_SUB:  fn_sel = SEL_SUB;
               FN_AND:  fn_sel = SEL_AND;
               FN_OR:   fn_sel = SEL_OR;
               FN_SLT:  fn_sel = SEL_SLT;
               default: fn_bad = 1'b1;
            endcase
         end
      end else begin : g_nibble
         // reduced decode: bit 5 set, low nibble picks the operation
         logic [3:0] nib;
         assign nib = fcode[3:0];
         always_comb begin
            fn_sel = SEL_ADD;
            fn_bad = !fcode[5];
            unique case (nib)
               4'h0:    fn_sel = SEL_ADD;
               4'h2:    fn_sel = SEL_SUB;
               4'h4:    fn_sel = SEL_AND;
               4'h5:    fn_sel = SEL_OR;
               4'hA:    fn_sel = SEL_SLT;
               default: fn_bad = 1'b1;
            endcase
            if (fn_bad) fn_sel = SEL_ADD;
         end
      end
   endgenerate

   always_comb begin
      assert_fn_bad_defaults_add_R4: assert (!fn_bad || fn_sel == SEL_ADD)
         else $error("unsupported funct did not default to add");
   end

endmodule

// File: rtl/alu_op_decoder.sv
module alu_op_decoder
   import alu_op_pkg::*;
#(
   parameter int FUNCT_W      = 6,
   parameter int SEL_W        = 3,
   parameter bit STRICT_FUNCT = 1'b1
) (
   input  logic [CLASS_BITS-1:0] op_class,
   input  logic [FUNCT_W-1:0]    funct,
   output logic [SEL_W-1:0]      alu_sel,
   output logic                  illegal_funct
);

   generate
      if (SEL_W != OPSEL_BITS) begin : g_bad_sel_w
         $error("SEL_W must match the 3-bit select encoding");
      end
      if (FUNCT_W < 6) begin : g_bad_funct_w
         $error("FUNCT_W must cover a 6-bit function field");
      end
   endgenerate

   logic [SEL_W-1:0] base_sel;
   logic [SEL_W-1:0] fn_sel;
   logic             use_funct;
   logic             cls_bad;
   logic             fn_bad;

   op_class_map #(
      .SEL_W     (SEL_W)
   ) u_cls (
      .cls       (op_class),
      .base_sel  (base_sel),
      .use_funct (use_funct),
      .cls_bad   (cls_bad)
   );

   funct_op_map #(
      .FUNCT_W      (FUNCT_W),
      .SEL_W        (SEL_W),
      .STRICT_FUNCT (STRICT_FUNCT)
   ) u_fn (
      .funct  (funct),
      .fn_sel (fn_sel),
      .fn_bad (fn_bad)
   );

   always_comb begin
      alu_sel       = use_funct ? fn_sel : base_sel;
      illegal_funct = cls_bad | (use_funct & fn_bad);
   end

   // port-level checks
   always_comb begin
      assert_mem_adds_R1: assert (op_class != 2'b00 ||
                                  (alu_sel == SEL_ADD && !illegal_funct))
         else $error("load/store class must add");
      assert_branch_subs_R2: assert (op_class != 2'b01 ||
                                     (alu_sel == SEL_SUB && !illegal_funct))
         else $error("branch class must subtract");
      assert_rsvd_flagged_R5: assert (op_class != 2'b11 ||
                                      (alu_sel == SEL_ADD && illegal_funct))
         else $error("reserved class must flag and add");
      assert_sel_in_set_R7: assert (sel_is_legal(alu_sel))
         else $error("select outside the encoding set");
   end

endmodule

// File: tb/sim_alu_op_decoder.sv
module sim_alu_op_decoder;

   localparam int NV = 17;

   logic       clk = 1'b0;
   logic [1:0] op_class;
   logic [5:0] funct;
   logic [2:0] alu_sel;
   logic       illegal_funct;
   int         n_chk = 0;
   int         n_bad = 0;

   always #5 clk = ~clk;

   alu_op_decoder u0 (
      .op_class      (op_class),
      .funct         (funct),
      .alu_sel       (alu_sel),
      .illegal_funct (illegal_funct)
   );

   // {req[3:0], class[1:0], funct[5:0], sel[2:0], illegal}
   localparam logic [15:0] VEC [NV] = '{
      {4'd1, 2'b00, 6'h00, 3'b010, 1'b0},
      {4'd1, 2'b00, 6'h24, 3'b010, 1'b0},
      {4'd1, 2'b00, 6'h2A, 3'b010, 1'b0},
      {4'd2, 2'b01, 6'h05, 3'b110, 1'b0},
      {4'd2, 2'b01, 6'h24, 3'b110, 1'b0},
      {4'd3, 2'b10, 6'h20, 3'b010, 1'b0},
      {4'd3, 2'b10, 6'h22, 3'b110, 1'b0},
      {4'd3, 2'b10, 6'h24, 3'b000, 1'b0},
      {4'd3, 2'b10, 6'h25, 3'b001, 1'b0},
      {4'd3, 2'b10, 6'h2A, 3'b111, 1'b0},
      {4'd4, 2'b10, 6'h21, 3'b010, 1'b1},
      {4'd4, 2'b10, 6'h3F, 3'b010, 1'b1},
      {4'd4, 2'b10, 6'h00, 3'b010, 1'b1},
      {4'd4, 2'b10, 6'h2B, 3'b010, 1'b1},
      {4'd4, 2'b10, 6'h0A, 3'b010, 1'b1},
      {4'd5, 2'b11, 6'h20, 3'b010, 1'b1},
      {4'd5, 2'b11, 6'h00, 3'b010, 1'b1}
   };

   // expected select from the requirements
   function automatic logic [3:0] expect_out(logic [1:0] c, logic [5:0] f);
      case (c)
         2'b00: return {3'b010, 1'b0};
         2'b01: return {3'b110, 1'b0};
         2'b10: case (f)
            6'h20: return {3'b010, 1'b0};
            6'h22: return {3'b110, 1'b0};
            6'h24: return {3'b000, 1'b0};
            6'h25: return {3'b001, 1'b0};
            6'h2A: return {3'b111, 1'b0};
            default: return {3'b010, 1'b1};
         endcase
         default: return {3'b010, 1'b1};
      endcase
   endfunction

   // reference 32-bit ALU driven by a select
   function automatic logic [31:0] ref_alu(logic [2:0] s, logic [31:0] a, logic [31:0] b);
      logic [31:0] bb;
      logic [31:0] sum;
      bb  = s[2] ? ~b : b;
      sum = a + bb + {31'd0, s[2]};
      case (s[1:0])
         2'b00: return a & b;
         2'b01: return a | b;
         2'b10: return sum;
         default: return {31'd0, (a[31] ^ b[31]) ? a[31] : sum[31]};
      endcase
   endfunction

   // intended result for a function code
   function automatic logic [31:0] intent(logic [5:0] f, logic [31:0] a, logic [31:0] b);
      case (f)
         6'h20: return a + b;
         6'h22: return a - b;
         6'h24: return a & b;
         6'h25: return a | b;
         default: return ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
      endcase
   endfunction

   task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got %h expected %h", tag, got, exp);
      end
   endtask

   task automatic apply(logic [1:0] c, logic [5:0] f);
      @(posedge clk);
      op_class <= c;
      funct    <= f;
      @(negedge clk);
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: run did not complete");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin : main
      logic [3:0] e;
      logic [31:0] opa [5];
      logic [31:0] opb [5];
      logic [5:0] afn [5];
      opa = '{32'd7, 32'hFFFF_FFFF, 32'h8000_0000, 32'd5, 32'h7FFF_FFFF};
      opb = '{32'd9, 32'd1, 32'd1, 32'd5, 32'hFFFF_FFFF};
      afn = '{6'h20, 6'h22, 6'h24, 6'h25, 6'h2A};

      // idle state: no reset exists, all-zero inputs give the load/store add (R1)
      apply(2'b00, 6'h00);
      check("R1 idle select", {29'd0, alu_sel}, 32'd2);
      check("R1 idle flag", {31'd0, illegal_funct}, 32'd0);

      // vector table
      for (int i = 0; i < NV; i++) begin
         apply(VEC[i][11:10], VEC[i][9:4]);
         check($sformatf("R%0d vec %0d sel", VEC[i][15:12], i),
               {29'd0, alu_sel}, {29'd0, VEC[i][3:1]});
         check($sformatf("R%0d vec %0d flag", VEC[i][15:12], i),
               {31'd0, illegal_funct}, {31'd0, VEC[i][0]});
      end

      // exhaustive sweep: R6 (don't-care under 00/01), R3/R4 (class 10), R5 (class 11), R7
      for (int c = 0; c < 4; c++) begin
         for (int f = 0; f < 64; f++) begin
            apply(c[1:0], f[5:0]);
            e = expect_out(c[1:0], f[5:0]);
            check($sformatf("%s sweep cls %0d fn %h",
                            c == 0 || c == 1 ? "R6" : (c == 3 ? "R5" : "R3_R4"), c, f),
                  {28'd0, alu_sel, illegal_funct}, {28'd0, e});
            check($sformatf("R7 sel in set cls %0d fn %h", c, f),
                  {31'd0, (alu_sel == 3'b000 || alu_sel == 3'b001 || alu_sel == 3'b010 ||
                           alu_sel == 3'b110 || alu_sel == 3'b111)}, 32'd1);
         end
      end

      // R8: decoded select drives reference ALU to the intended result
      for (int k = 0; k < 5; k++) begin
         for (int p = 0; p < 5; p++) begin
            apply(2'b10, afn[k]);
            check($sformatf("R8 fn %h a %h b %h", afn[k], opa[p], opb[p]),
                  ref_alu(alu_sel, opa[p], opb[p]), intent(afn[k], opa[p], opb[p]));
         end
      end
      // R8 via classes: memory add and branch compare
      apply(2'b00, 6'h2A);
      check("R8 mem address add", ref_alu(alu_sel, 32'h1000, 32'h64), 32'h1064);
      apply(2'b01, 6'h25);
      check("R8 branch equal zero", ref_alu(alu_sel, 32'h55, 32'h55), 32'd0);

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

endmodule